// File: doc/BRIEF.md
# Shared-Bus Accumulator Machine Sequencer

This block is the control unit and datapath of a very small accumulator computer. An instruction register, an accumulator, an operand register B, a program counter, an adder with a zero/carry flag register and a 32-entry memory all share one 8-bit data bus. For each instruction the sequencer fetches a word, decodes it and issues a fixed series of micro-steps. In each micro-step it raises one set of separate strobes. Each strobe either lets one unit drive the bus or lets one unit load from it.

The machine runs three instructions: load accumulator, add to accumulator and jump. It treats every other opcode as a no-operation. Each memory read follows a two-cycle handshake: the read line goes low for one wait cycle, and the data is on the bus once the line returns high. A test environment fills the memory through a write port, normally while reset is held. Debug outputs show the current micro-step code and the strobe vector, so the exact cycle sequence can be followed from the outside.

Top module: `acc_seq_top`

## Requirements
- R1: A synchronous active-high reset clears the PC, the accumulator, B and both flags, and parks the machine at micro-step 0 (strobe vector equal to the PC-drive strobe, read line high).
- R2: The strobe vector bits are: 0 IR drives, 1 IR loads, 2 ACC loads, 3 B loads, 4 PC drives, 5 PC loads, 6 PC increments, 7 memory drives, 8 ALU drives, 9 flags load. At most one of the drive strobes (bits 0, 4, 7, 8) is high in any cycle, and the bus reads 0 when none is high.
- R3: Fetch takes four cycles with step codes 0 (PC drives the address, bus = PC), 1 (wait), 2 (memory drives the instruction word), 3 (memory drives, IR loads, PC increments). The PC counts modulo 32.
- R4: Each memory read holds the read line low for exactly one cycle, step 1 or 5. In the next cycle the line is high and the bus carries the word at the latched address.
- R5: The instruction word has the opcode in bits 7:5 and the operand address in bits 4:0. Opcode 001 (load) runs steps 4 (IR drives the address, bus = operand), 5, 6 and 7 (memory drives, ACC loads) and leaves ACC equal to the memory word.
- R6: Opcode 010 (add) runs steps 4, 5, 6, then 8 (memory drives, B loads), then 9 (ALU drives, ACC and flags load). ACC ends as (ACC + word) mod 256.
- R7: Only the add instruction changes the flags. Zero is set when the 8-bit sum is 0, and carry is bit 8 of the 9-bit sum.
- R8: Opcode 011 (jump) runs step 4, then step 10 (PC loads the latched target, no bus driver). The next fetch starts at the operand address.
- R9: Opcodes 000 and 100 to 111 perform only the fetch, then return to step 0 with ACC and the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Memory fill write enable |
| prog_addr | input | 5 | Memory fill address |
| prog_data | input | 8 | Memory fill data |
| data_bus | output | 8 | Value on the shared data bus |
| addr_bus | output | 5 | Latched memory address |
| mem_rd_n | output | 1 | Memory read line, active low |
| acc_out | output | 8 | Accumulator |
| pc_out | output | 5 | Program counter |
| zero_flag | output | 1 | Zero flag |
| carry_flag | output | 1 | Carry flag |
| dbg_step | output | 4 | Current micro-step code |
| dbg_strobe | output | 10 | Active strobe vector |

## Verification
A wrong step transition shows on the debug step and strobe outputs in the very next cycle, because every cycle is checked against the expected micro-step, strobe set, read line and bus value. A wrong accumulator, PC or flag value, for example a dropped carry or a PC that does not wrap, shows on the state outputs within one cycle of the faulty load. It also spreads to the bus values of the instructions that follow. A bad latched address shows two cycles later, as a wrong word on the bus in the data step of the read.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

    localparam int WORD_W  = 8;
    localparam int ADR_W   = 5;
    localparam int OPC_W   = WORD_W - ADR_W;
    localparam int STEP_W  = 4;
    localparam int NSTROBE = 10;

    localparam logic [2:0] OPC_LDA = 3'b001;
    localparam logic [2:0] OPC_ADD = 3'b010;
    localparam logic [2:0] OPC_JMP = 3'b011;

    // strobe bit positions
    localparam int SB_IR_RD  = 0;
    localparam int SB_IR_WR  = 1;
    localparam int SB_ACC_WR = 2;
    localparam int SB_B_WR   = 3;
    localparam int SB_PC_RD  = 4;
    localparam int SB_PC_WR  = 5;
    localparam int SB_PC_INC = 6;
    localparam int SB_MEM_RD = 7;
    localparam int SB_ALU_RD = 8;
    localparam int SB_FLG_WR = 9;

    typedef logic [NSTROBE-1:0] strobe_t;

    typedef enum logic [STEP_W-1:0] {
        ST_FPC   = 4'd0,
        ST_FWAIT = 4'd1,
        ST_FDATA = 4'd2,
        ST_FIR   = 4'd3,
        ST_EIR   = 4'd4,
        ST_EWAIT = 4'd5,
        ST_EDATA = 4'd6,
        ST_EACC  = 4'd7,
        ST_EB    = 4'd8,
        ST_EALU  = 4'd9,
        ST_EPC   = 4'd10
    } step_e;

    typedef enum logic {
        ALU_PASS = 1'b0,
        ALU_ADD  = 1'b1
    } alu_op_e;

    typedef struct packed {
        logic zero;
        logic carry;
    } flags_t;

    // Fixed strobe set of each micro-step.
    function automatic strobe_t step_strobes(step_e s);
        strobe_t v;
        v = '0;
        case (s)
            ST_FPC:   v[SB_PC_RD] = 1'b1;
            ST_FWAIT, ST_FDATA, ST_EWAIT, ST_EDATA:
                      v[SB_MEM_RD] = 1'b1;
            ST_FIR: begin
                v[SB_MEM_RD] = 1'b1;
                v[SB_IR_WR]  = 1'b1;
                v[SB_PC_INC] = 1'b1;
            end
            ST_EIR:   v[SB_IR_RD] = 1'b1;
            ST_EACC: begin
                v[SB_MEM_RD] = 1'b1;
                v[SB_ACC_WR] = 1'b1;
            end
            ST_EB: begin
                v[SB_MEM_RD] = 1'b1;
                v[SB_B_WR]   = 1'b1;
            end
            ST_EALU: begin
                v[SB_ALU_RD] = 1'b1;
                v[SB_ACC_WR] = 1'b1;
                v[SB_FLG_WR] = 1'b1;
            end
            ST_EPC:   v[SB_PC_WR] = 1'b1;
            default:  v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int OP_W = acc_seq_pkg::OPC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] fetch_op,
    input  logic [OP_W-1:0] ir_op,
    output step_e           step_q,
    output strobe_t         strobes,
    output logic            mem_rd_n,
    output alu_op_e         alu_op
);

    step_e step_d;

    always_comb begin
        step_d = ST_FPC;
        case (step_q)
            ST_FPC:   step_d = ST_FWAIT;
            ST_FWAIT: step_d = ST_FDATA;
            ST_FDATA: step_d = ST_FIR;
            ST_FIR: begin
                if (fetch_op == OP_W'(OPC_LDA) || fetch_op == OP_W'(OPC_ADD) ||
                    fetch_op == OP_W'(OPC_JMP))
                    step_d = ST_EIR;
                else
                    step_d = ST_FPC;
            end
            ST_EIR:   step_d = (ir_op == OP_W'(OPC_JMP)) ? ST_EPC : ST_EWAIT;
            ST_EWAIT: step_d = ST_EDATA;
            ST_EDATA: step_d = (ir_op == OP_W'(OPC_ADD)) ? ST_EB : ST_EACC;
            ST_EB:    step_d = ST_EALU;
            default:  step_d = ST_FPC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_FPC;
        else     step_q <= step_d;
    end

    assign strobes  = step_strobes(step_q);
    assign mem_rd_n = !(step_q == ST_FWAIT || step_q == ST_EWAIT);
    assign alu_op   = (step_q == ST_EALU) ? ALU_ADD : ALU_PASS;

    // R2: never more than one bus driver
    a_r2_single_driver: assert property (@(posedge clk) disable iff (rst)
        $countones({strobes[SB_IR_RD], strobes[SB_PC_RD],
                    strobes[SB_MEM_RD], strobes[SB_ALU_RD]}) <= 1);

    // R4: the read line is low for one cycle only, memory drives next
    a_r4_wait_one_cycle: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_n |=> (mem_rd_n && strobes[SB_MEM_RD]));

endmodule

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
    parameter int DATA_W = acc_seq_pkg::WORD_W,
    parameter int ADDR_W = acc_seq_pkg::ADR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_we,
    input  logic [ADDR_W-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_n,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] arr [DEPTH];

    always_ff @(posedge clk) begin
        if (prog_we) arr[prog_addr] <= prog_data;
    end

    // The word is captured during the low phase of the read line and is
    // valid on the output once the line is high again.
    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (!rd_n) rdata <= arr[addr];
    end

    // R4: the output word only moves after a read-line low cycle
    a_r4_data_after_strobe: assert property (@(posedge clk) disable iff (rst)
        !$stable(rdata) |-> $past(!rd_n));

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = acc_seq_pkg::WORD_W
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);

    logic [DATA_W:0] sum;

    always_comb begin
        sum = {1'b0, a} + {1'b0, b};
        if (op == ALU_ADD) begin
            result      = sum[DATA_W-1:0];
            flags.carry = sum[DATA_W];
        end else begin
            result      = a;
            flags.carry = 1'b0;
        end
        flags.zero = (result == '0);
    end

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
    import acc_seq_pkg::*;
#(
    parameter int DATA_W = acc_seq_pkg::WORD_W,
    parameter int ADDR_W = acc_seq_pkg::ADR_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 prog_we,
    input  logic [ADDR_W-1:0]    prog_addr,
    input  logic [DATA_W-1:0]    prog_data,
    output logic [DATA_W-1:0]    data_bus,
    output logic [ADDR_W-1:0]    addr_bus,
    output logic                 mem_rd_n,
    output logic [DATA_W-1:0]    acc_out,
    output logic [ADDR_W-1:0]    pc_out,
    output logic                 zero_flag,
    output logic                 carry_flag,
    output logic [STEP_W-1:0]    dbg_step,
    output logic [NSTROBE-1:0]   dbg_strobe
);

    localparam int OP_W  = DATA_W - ADDR_W;
    localparam int PAD_W = DATA_W - ADDR_W;

    step_e             step_q;
    strobe_t           strobes;
    alu_op_e           alu_op;
    flags_t            alu_flags;
    flags_t            flags_q;
    logic [DATA_W-1:0] ir_q, acc_q, b_q, mem_rdata, alu_result, bus;
    logic [ADDR_W-1:0] pc_q, addr_q;

    acc_seq_ctrl #(.OP_W(OP_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fetch_op (bus[DATA_W-1 -: OP_W]),
        .ir_op    (ir_q[DATA_W-1 -: OP_W]),
        .step_q   (step_q),
        .strobes  (strobes),
        .mem_rd_n (mem_rd_n),
        .alu_op   (alu_op)
    );

    acc_seq_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .addr      (addr_q),
        .rd_n      (mem_rd_n),
        .rdata     (mem_rdata)
    );

    acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (alu_op),
        .a      (acc_q),
        .b      (b_q),
        .result (alu_result),
        .flags  (alu_flags)
    );

    // shared bus: the single active driver wins, idle bus reads zero
    always_comb begin
        bus = '0;
        if (strobes[SB_IR_RD])       bus = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
        else if (strobes[SB_PC_RD])  bus = {{PAD_W{1'b0}}, pc_q};
        else if (strobes[SB_MEM_RD]) bus = mem_rdata;
        else if (strobes[SB_ALU_RD]) bus = alu_result;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q    <= '0;
            acc_q   <= '0;
            b_q     <= '0;
            pc_q    <= '0;
            addr_q  <= '0;
            flags_q <= '0;
        end else begin
            if (strobes[SB_IR_WR])  ir_q  <= bus;
            if (strobes[SB_ACC_WR]) acc_q <= bus;
            if (strobes[SB_B_WR])   b_q   <= bus;
            if (strobes[SB_PC_RD] || strobes[SB_IR_RD])
                addr_q <= bus[ADDR_W-1:0];
            if (strobes[SB_PC_WR])       pc_q <= addr_q;
            else if (strobes[SB_PC_INC]) pc_q <= pc_q + ADDR_W'(1);
            if (strobes[SB_FLG_WR]) flags_q <= alu_flags;
        end
    end

    assign data_bus   = bus;
    assign addr_bus   = addr_q;
    assign acc_out    = acc_q;
    assign pc_out     = pc_q;
    assign zero_flag  = flags_q.zero;
    assign carry_flag = flags_q.carry;
    assign dbg_step   = step_q;
    assign dbg_strobe = strobes;

    // R3: fetch's last step advances the PC by one, modulo the address space
    a_r3_fetch_advances_pc: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_FIR) |=> (pc_q == $past(pc_q) + ADDR_W'(1)));

    // R8: a jump lands on the operand held in the instruction register
    a_r8_jump_target: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_EPC) |=> (pc_q == $past(ir_q[ADDR_W-1:0])));

    // R7: flag loads only ever occur under an add instruction
    a_r7_flags_only_on_add: assert property (@(posedge clk) disable iff (rst)
        strobes[SB_FLG_WR] |-> (ir_q[DATA_W-1 -: OP_W] == OP_W'(OPC_ADD)));

    // R7: a load step leaves the flags untouched
    a_r7_load_keeps_flags: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_EACC) |=> $stable(flags_q));

endmodule

// File: tb/acc_seq_top_test.sv
`timescale 1ns/1ps
module acc_seq_top_test;

    localparam logic [9:0] S_IR_RD  = 10'h001;
    localparam logic [9:0] S_IR_WR  = 10'h002;
    localparam logic [9:0] S_ACC_WR = 10'h004;
    localparam logic [9:0] S_B_WR   = 10'h008;
    localparam logic [9:0] S_PC_RD  = 10'h010;
    localparam logic [9:0] S_PC_WR  = 10'h020;
    localparam logic [9:0] S_PC_INC = 10'h040;
    localparam logic [9:0] S_MEM    = 10'h080;
    localparam logic [9:0] S_ALU_RD = 10'h100;
    localparam logic [9:0] S_FLG_WR = 10'h200;

    typedef struct {
        logic [3:0] step;
        logic [9:0] sb;
        logic       rdn;
        logic       bchk;
        logic [7:0] bus;
        logic [4:0] pc;
        logic [7:0] acc;
        logic       z;
        logic       c;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [4:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic [7:0] data_bus, acc_out;
    logic [4:0] addr_bus, pc_out;
    logic       mem_rd_n, zero_flag, carry_flag;
    logic [3:0] dbg_step;
    logic [9:0] dbg_strobe;

    int compared = 0;
    int mismatched = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;
    bit nop_before = 1'b0;
    item_t exp_q[$];

    logic [7:0] m_mem [32];
    logic [4:0] m_pc;
    logic [7:0] m_acc;
    logic       m_z, m_c;

    always #2 clk = ~clk;

    acc_seq_top uut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .data_bus(data_bus), .addr_bus(addr_bus),
        .mem_rd_n(mem_rd_n), .acc_out(acc_out), .pc_out(pc_out),
        .zero_flag(zero_flag), .carry_flag(carry_flag),
        .dbg_step(dbg_step), .dbg_strobe(dbg_strobe)
    );

    task automatic push(input logic [3:0] st, input logic [9:0] sb, input logic rdn,
                        input logic bchk, input logic [7:0] bv, input string tag);
        item_t it;
        it.step = st; it.sb = sb; it.rdn = rdn; it.bchk = bchk; it.bus = bv;
        it.pc = m_pc; it.acc = m_acc; it.z = m_z; it.c = m_c; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Driver: expands one instruction of the model program into cycles.
    task automatic run_one();
        logic [7:0] word;
        logic [4:0] a;
        logic [8:0] sum;
        word = m_mem[m_pc];
        a = word[4:0];
        push(4'd0, S_PC_RD, 1'b1, 1'b1, {3'b0, m_pc}, nop_before ? "R9" : "R3");
        push(4'd1, S_MEM, 1'b0, 1'b0, 8'h00, "R4");
        push(4'd2, S_MEM, 1'b1, 1'b1, word, "R4");
        push(4'd3, S_MEM | S_IR_WR | S_PC_INC, 1'b1, 1'b1, word, "R3");
        m_pc = m_pc + 5'd1;
        nop_before = 1'b0;
        case (word[7:5])
            3'b001: begin
                push(4'd4, S_IR_RD, 1'b1, 1'b1, {3'b0, a}, "R5");
                push(4'd5, S_MEM, 1'b0, 1'b0, 8'h00, "R4");
                push(4'd6, S_MEM, 1'b1, 1'b1, m_mem[a], "R5");
                push(4'd7, S_MEM | S_ACC_WR, 1'b1, 1'b1, m_mem[a], "R5");
                m_acc = m_mem[a];
            end
            3'b010: begin
                push(4'd4, S_IR_RD, 1'b1, 1'b1, {3'b0, a}, "R6");
                push(4'd5, S_MEM, 1'b0, 1'b0, 8'h00, "R4");
                push(4'd6, S_MEM, 1'b1, 1'b1, m_mem[a], "R6");
                push(4'd8, S_MEM | S_B_WR, 1'b1, 1'b1, m_mem[a], "R6");
                sum = {1'b0, m_acc} + {1'b0, m_mem[a]};
                push(4'd9, S_ALU_RD | S_ACC_WR | S_FLG_WR, 1'b1, 1'b1, sum[7:0], "R6");
                m_acc = sum[7:0];
                m_z = (sum[7:0] == 8'h00);   // R7 zero
                m_c = sum[8];                 // R7 carry
            end
            3'b011: begin
                push(4'd4, S_IR_RD, 1'b1, 1'b1, {3'b0, a}, "R8");
                push(4'd10, S_PC_WR, 1'b1, 1'b1, 8'h00, "R8,R2");
                m_pc = a;
            end
            default: nop_before = 1'b1;
        endcase
    endtask

    task automatic model_reset();
        m_pc = '0; m_acc = '0; m_z = 1'b0; m_c = 1'b0; nop_before = 1'b0;
    endtask

    task automatic check_reset(input string when);
        compared++;
        if (dbg_step !== 4'd0 || dbg_strobe !== S_PC_RD || mem_rd_n !== 1'b1 ||
            pc_out !== 5'd0 || acc_out !== 8'h00 || zero_flag !== 1'b0 ||
            carry_flag !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 %s: step=%0d sb=%h rdn=%b pc=%h acc=%h z=%b c=%b expected step=0 sb=%h rdn=1 pc=0 acc=0 z=0 c=0",
                     when, dbg_step, dbg_strobe, mem_rd_n, pc_out, acc_out,
                     zero_flag, carry_flag, S_PC_RD);
        end
    endtask

    // Monitor: pops one expected cycle per clock and compares at the ports.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_en && exp_q.size() > 0) begin
                item_t e;
                e = exp_q.pop_front();
                compared++;
                if (dbg_step !== e.step || dbg_strobe !== e.sb || mem_rd_n !== e.rdn ||
                    (e.bchk && data_bus !== e.bus) || pc_out !== e.pc ||
                    acc_out !== e.acc || zero_flag !== e.z || carry_flag !== e.c) begin
                    mismatched++;
                    $display("FAIL %s: step=%0d sb=%h rdn=%b bus=%h pc=%h acc=%h z=%b c=%b expected step=%0d sb=%h rdn=%b bus=%h(chk %b) pc=%h acc=%h z=%b c=%b",
                             e.tag, dbg_step, dbg_strobe, mem_rd_n, data_bus, pc_out,
                             acc_out, zero_flag, carry_flag, e.step, e.sb, e.rdn,
                             e.bus, e.bchk, e.pc, e.acc, e.z, e.c);
                end
            end
        end
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_mem[i] = 8'h00;
        m_mem[0]  = 8'h34;  // load [20]
        m_mem[1]  = 8'h55;  // add [21] -> carry out
        m_mem[2]  = 8'h36;  // load [22] = 0, flags kept (R7)
        m_mem[3]  = 8'h56;  // add [22] -> zero
        m_mem[4]  = 8'h00;  // nop opcode 000 (R9)
        m_mem[5]  = 8'hFF;  // nop opcode 111 (R9)
        m_mem[6]  = 8'h37;  // load [23]
        m_mem[7]  = 8'h57;  // add [23] -> zero and carry
        m_mem[8]  = 8'h6C;  // jump 12
        m_mem[9]  = 8'h36;  // skipped
        m_mem[10] = 8'h36;  // skipped
        m_mem[11] = 8'h36;  // skipped
        m_mem[12] = 8'h58;  // add [24]
        m_mem[13] = 8'h7F;  // jump 31
        m_mem[20] = 8'hF0;
        m_mem[21] = 8'h20;
        m_mem[22] = 8'h00;
        m_mem[23] = 8'h80;
        m_mem[24] = 8'h01;
        m_mem[31] = 8'h34;  // load [20], PC then wraps to 0 (R3)

        // fill memory while reset is held
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 5'(i); prog_data = m_mem[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
        #1;
        check_reset("after power-up reset");

        // run the program through the scoreboard
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int n = 0; n < 13; n++) run_one();
        mon_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        mon_en = 1'b0;

        // reset in the middle of an instruction
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        #1;
        check_reset("after mid-run reset");

        // restart from address 0 after reset
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        for (int n = 0; n < 3; n++) run_one();
        mon_en = 1'b1;
        while (exp_q.size() > 0) @(negedge clk);
        mon_en = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule